// File: doc/BRIEF.md
# Glitch-Free Clock Output Gating Controller

This block sits after the clock synthesizers of a system clock generator and turns the clocks they already produce into the gated clocks seen at the output pins. It receives a 33 MHz clock, a 66 MHz clock, a reference clock and one clock per differential CPU pair. It drives a bank of PCI outputs, one dedicated free-running PCI output, a four-output group that can run at 33 MHz or 66 MHz, reference outputs and the CPU true/complement pairs.

Every output has a run bit. The PCI outputs also answer an active-low stop input, and an output marked free-running in the parameter mask can be exempted from the stop through its own free-running bit. Each gate samples its run request through a synchronizer in its own clock domain. It updates its gate flop only on the falling edge of that clock. As a result, starting or stopping an output never cuts a high phase short, and a stopped output always rests low.

Straps are loaded into holding flops on every reference clock edge while reset is asserted, and they freeze once reset is released. The frozen values are the group speed split, the 24/48 MHz select and the 4-bit frequency code. Later changes on the strap inputs have no effect. A frozen frequency code of zero clears all output-enable bits, which puts every output into high impedance.

Top module: `clk_out_gater`

## Requirements
- R1: While `pci_stop_n` is 0, every PCI output outside the free-running mask stops and rests low. `pcif_clk` is never affected by `pci_stop_n`.
- R2: A PCI output whose bit is set in `FREERUN_MASK` (default outputs 3, 4 and 5) keeps running through a stop when its `pci_freerun` bit is 1. A `pci_freerun` bit on an output outside the mask has no effect.
- R3: The frozen 2-bit group select value n makes the last n group outputs (the highest indices) run at 33 MHz and the rest run at 66 MHz. So 00 gives all 66 MHz, 01 gives only output 3 at 33 MHz, 10 gives outputs 2–3 at 33 MHz, and 11 leaves only output 0 at 66 MHz.
- R4: `pci_stop_n` = 0 stops only the group outputs that currently run at 33 MHz. Group outputs at 66 MHz keep toggling.
- R5: A PCI, free-running PCI or group output whose run bit is 0 stops and rests low. A run bit of 1 lets the output run.
- R6: A CPU pair whose `cpu_run` bit is 0 holds its true output low and its complement output high. A running pair drives the complement as the inverse of the true output.
- R7: A gate changes state only while its source clock is low, so no output produces a runt pulse or a truncated high phase.
- R8: A frozen frequency code of 0000 drives all `out_oe` bits to 0. Any other code drives them all to 1.
- R9: Straps are frozen when reset is released. Later changes to `strap_grp_sel`, `strap_fsel` or `strap_fdc24` change nothing. `fdc_is_24` reports the frozen 24/48 select, where 1 means 24 MHz and 0 means 48 MHz.
- R10: While `rst_n` is 0, every clock output rests low and every CPU complement output rests high.
- R11: A reference output runs when its `ref_en` bit is 1 and rests low when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_33 | input | 1 | 33 MHz source clock |
| clk_66 | input | 1 | 66 MHz source clock |
| clk_ref | input | 1 | Reference source clock; it also clocks the strap flops |
| clk_cpu | input | NCPU | One source clock per CPU pair |
| rst_n | input | 1 | Synchronous active-low reset, applied in each clock domain |
| pci_stop_n | input | 1 | Active-low stop for the 33 MHz PCI outputs |
| pci_en | input | NPCI | Run bits of the PCI outputs |
| pci_freerun | input | NPCI | Free-running bits; they act only where FREERUN_MASK is set |
| pcif_en | input | 1 | Run bit of the dedicated free-running PCI output |
| grp_en | input | NGRP | Run bits of the 33/66 MHz group |
| ref_en | input | NREF | Run bits of the reference outputs |
| cpu_run | input | NCPU | Run bits of the CPU pairs (0 = shut down) |
| strap_grp_sel | input | $clog2(NGRP) | Group split strap, frozen when reset is released |
| strap_fsel | input | 4 | Frequency code strap, frozen when reset is released |
| strap_fdc24 | input | 1 | 24/48 MHz select strap, frozen when reset is released |
| pci_clk | output | NPCI | Gated PCI clocks |
| pcif_clk | output | 1 | Gated free-running PCI clock |
| grp_clk | output | NGRP | Gated group clocks at 33 or 66 MHz |
| ref_clk | output | NREF | Gated reference clocks |
| cpu_clk_t | output | NCPU | CPU pair true outputs |
| cpu_clk_c | output | NCPU | CPU pair complement outputs |
| fdc_is_24 | output | 1 | Frozen 24/48 select (1 = 24 MHz) |
| out_oe | output | NPCI+1+NGRP+NREF+NCPU | Output enables, in order: PCI, free PCI, group, reference, CPU pairs (LSB first) |

## Verification
The checker runs on every cycle. It checks that each gate flop changes only while its own source clock is low. It checks that a stop held for four edges has cleared every non-exempt PCI gate, and that the same stop leaves 66 MHz group gates open. It checks that a CPU pair held off has a closed gate, and that the frozen straps never move after reset is released.

Some properties appear only as output frequencies and levels, so only the bench scenarios can show them. These are the 33/66 MHz split for each strap value, the free-running exemption, the parked levels of the outputs and the complement pin, the output-enable response to the frequency code, and the fact that late strap changes are ignored.

// File: rtl/clk_out_gater_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the clock output gating controller.
// Assumes the group select value counts how many of the highest-index group
// outputs run at the slow (33 MHz) rate.
package clk_out_gater_pkg;

    localparam int FSEL_W = 4;

    // Decide whether group output idx runs at the slow rate for split value n.
    function automatic logic grp_is_slow(input int idx, input int ngrp, input int n);
        return (idx >= (ngrp - n));
    endfunction

endpackage

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
// One glitch-free clock gate.
// The run request is asynchronous to clk. It passes through SYNC_STAGES flops
// on the rising edge and is then captured on the falling edge. The gated clock
// is clk ANDed with that falling-edge flop, so the gate only opens or closes
// while clk is low, and a closed gate always rests low.
// Assumes rst_n is held for at least one full clk period.
module clk_gate_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic gate_on,
    output logic clk_out
);

    logic [SYNC_STAGES-1:0] sync_q;

    // Bring the asynchronous run request into this clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], run_req};
    end

    // Update the gate only while clk is low.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_on <= 1'b0;
        else        gate_on <= sync_q[SYNC_STAGES-1];
    end

    assign clk_out = clk & gate_on;

endmodule

// File: rtl/strap_hold.sv
`timescale 1ns/1ps
// Strap capture: loads the strap inputs on every clock edge while reset is
// asserted and holds them unchanged after reset is released.
// Assumes the straps are stable for a clock edge before reset is released.
module strap_hold #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] held
);

    // Follow the pins during reset, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= pins;
    end

endmodule

// File: rtl/clk_out_gater.sv
`timescale 1ns/1ps
// Clock output gating controller.
// Gates already generated 33 MHz, 66 MHz, reference and CPU clocks onto the
// output pins. There is one glitch-free gate per output, each in the domain of
// its source clock. A group of NGRP outputs is split between the 33 MHz and
// 66 MHz sources by a strap that is frozen when reset is released. The clock
// mux for a group output therefore changes only during reset, when its gate is
// held closed.
// Assumes all control inputs are asynchronous levels that change rarely.
module clk_out_gater
    import clk_out_gater_pkg::*;
#(
    parameter int              NPCI         = 8,
    parameter int              NGRP         = 4,
    parameter int              NREF         = 3,
    parameter int              NCPU         = 2,
    parameter logic [NPCI-1:0] FREERUN_MASK = 8'b0011_1000
) (
    input  logic                    clk_33,
    input  logic                    clk_66,
    input  logic                    clk_ref,
    input  logic [NCPU-1:0]         clk_cpu,
    input  logic                    rst_n,
    input  logic                    pci_stop_n,
    input  logic [NPCI-1:0]         pci_en,
    input  logic [NPCI-1:0]         pci_freerun,
    input  logic                    pcif_en,
    input  logic [NGRP-1:0]         grp_en,
    input  logic [NREF-1:0]         ref_en,
    input  logic [NCPU-1:0]         cpu_run,
    input  logic [$clog2(NGRP)-1:0] strap_grp_sel,
    input  logic [3:0]              strap_fsel,
    input  logic                    strap_fdc24,
    output logic [NPCI-1:0]         pci_clk,
    output logic                    pcif_clk,
    output logic [NGRP-1:0]         grp_clk,
    output logic [NREF-1:0]         ref_clk,
    output logic [NCPU-1:0]         cpu_clk_t,
    output logic [NCPU-1:0]         cpu_clk_c,
    output logic                    fdc_is_24,
    output logic [NPCI+NGRP+NREF+NCPU:0] out_oe
);

    localparam int GSEL_W  = $clog2(NGRP);
    localparam int STRAP_W = GSEL_W + FSEL_W + 1;
    localparam int NOUT    = NPCI + 1 + NGRP + NREF + NCPU;

    logic [STRAP_W-1:0] strap_q;
    logic [GSEL_W-1:0]  grp_sel_q;
    logic [FSEL_W-1:0]  fs_q;
    logic               fdc_q;

    logic [NPCI-1:0] pci_req, pci_on;
    logic [NGRP-1:0] grp_req, grp_on, grp_slow, grp_src;
    logic [NREF-1:0] ref_on;
    logic [NCPU-1:0] cpu_on;
    logic            pcif_on;

    strap_hold #(.W(STRAP_W)) u_strap (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .pins  ({strap_fdc24, strap_fsel, strap_grp_sel}),
        .held  (strap_q)
    );

    assign {fdc_q, fs_q, grp_sel_q} = strap_q;
    assign fdc_is_24 = fdc_q;
    assign out_oe    = {NOUT{fs_q != '0}};

    // PCI bank: the stop input applies unless the output is exempted.
    for (genvar i = 0; i < NPCI; i++) begin : g_pci
        if (FREERUN_MASK[i]) begin : g_free
            assign pci_req[i] = pci_en[i] & (pci_stop_n | pci_freerun[i]);
        end else begin : g_stoppable
            assign pci_req[i] = pci_en[i] & pci_stop_n;
        end
        clk_gate_cell u_gate (
            .clk (clk_33), .rst_n (rst_n), .run_req (pci_req[i]),
            .gate_on (pci_on[i]), .clk_out (pci_clk[i])
        );
    end

    clk_gate_cell u_pcif (
        .clk (clk_33), .rst_n (rst_n), .run_req (pcif_en),
        .gate_on (pcif_on), .clk_out (pcif_clk)
    );

    // Mixed group: the strap picks the source, and only slow members obey the stop.
    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        assign grp_slow[j] = grp_is_slow(j, NGRP, int'(grp_sel_q));
        assign grp_src[j]  = grp_slow[j] ? clk_33 : clk_66;
        assign grp_req[j]  = grp_en[j] & (pci_stop_n | ~grp_slow[j]);
        clk_gate_cell u_gate (
            .clk (grp_src[j]), .rst_n (rst_n), .run_req (grp_req[j]),
            .gate_on (grp_on[j]), .clk_out (grp_clk[j])
        );
    end

    for (genvar k = 0; k < NREF; k++) begin : g_ref
        clk_gate_cell u_gate (
            .clk (clk_ref), .rst_n (rst_n), .run_req (ref_en[k]),
            .gate_on (ref_on[k]), .clk_out (ref_clk[k])
        );
    end

    // CPU pairs: a closed gate gives true low and complement high.
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        clk_gate_cell u_gate (
            .clk (clk_cpu[c]), .rst_n (rst_n), .run_req (cpu_run[c]),
            .gate_on (cpu_on[c]), .clk_out (cpu_clk_t[c])
        );
        assign cpu_clk_c[c] = ~cpu_clk_t[c];
    end

endmodule

// File: rtl/clk_out_gater_chk.sv
`timescale 1ns/1ps
// Property checker for clk_out_gater, attached with bind.
// Observes gate flop states against their source clocks and control history.
module clk_out_gater_chk #(
    parameter int              NPCI         = 8,
    parameter int              NGRP         = 4,
    parameter int              NCPU         = 2,
    parameter logic [NPCI-1:0] FREERUN_MASK = 8'b0011_1000
) (
    input logic                    clk_33,
    input logic                    clk_66,
    input logic                    clk_ref,
    input logic [NCPU-1:0]         clk_cpu,
    input logic                    rst_n,
    input logic                    pci_stop_n,
    input logic [NGRP-1:0]         grp_en,
    input logic [NCPU-1:0]         cpu_run,
    input logic [NPCI-1:0]         pci_on,
    input logic [NGRP-1:0]         grp_on,
    input logic [NCPU-1:0]         cpu_on,
    input logic [NGRP-1:0]         grp_src,
    input logic [$clog2(NGRP)-1:0] grp_sel_q,
    input logic [3:0]              fs_q,
    input logic                    fdc_q
);

    for (genvar i = 0; i < NPCI; i++) begin : g_pci
        if (!FREERUN_MASK[i]) begin : g_stoppable
            // R1: a stop held over four edges has closed every non-exempt PCI gate.
            assert_stop_closes_R1: assert property (@(posedge clk_33) disable iff (!rst_n)
                ($past(rst_n, 3) && !pci_stop_n && !$past(pci_stop_n)
                 && !$past(pci_stop_n, 2) && !$past(pci_stop_n, 3)) |-> !pci_on[i]);
        end
        // R7: the gate flop moves only while the source clock is low.
        always @(pci_on[i]) if (rst_n) begin
            assert_gate_moves_low_R7: assert (!clk_33);
        end
    end

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        // R4: a 66 MHz group member with its run bit held stays open through a stop.
        assert_fast_ignores_stop_R4: assert property (@(posedge clk_66) disable iff (!rst_n)
            ($past(rst_n, 3) && (j < NGRP - int'(grp_sel_q)) && grp_en[j]
             && $past(grp_en[j]) && $past(grp_en[j], 2) && $past(grp_en[j], 3)) |-> grp_on[j]);
        // R7: group gates also move only while their selected source is low.
        always @(grp_on[j]) if (rst_n) begin
            assert_gate_moves_low_R7: assert (!grp_src[j]);
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        // R6: a pair shut down over four edges has a closed gate.
        assert_cpu_parks_R6: assert property (@(posedge clk_cpu[c]) disable iff (!rst_n)
            ($past(rst_n, 3) && !cpu_run[c] && !$past(cpu_run[c])
             && !$past(cpu_run[c], 2) && !$past(cpu_run[c], 3)) |-> !cpu_on[c]);
        // R7: CPU gates move only while their source is low.
        always @(cpu_on[c]) if (rst_n) begin
            assert_gate_moves_low_R7: assert (!clk_cpu[c]);
        end
    end

    // R9: frozen straps never change after reset is released.
    assert_straps_frozen_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(grp_sel_q) && $stable(fs_q) && $stable(fdc_q)));

endmodule

bind clk_out_gater clk_out_gater_chk #(
    .NPCI (NPCI), .NGRP (NGRP), .NCPU (NCPU), .FREERUN_MASK (FREERUN_MASK)
) u_chk (
    .clk_33     (clk_33),
    .clk_66     (clk_66),
    .clk_ref    (clk_ref),
    .clk_cpu    (clk_cpu),
    .rst_n      (rst_n),
    .pci_stop_n (pci_stop_n),
    .grp_en     (grp_en),
    .cpu_run    (cpu_run),
    .pci_on     (pci_on),
    .grp_on     (grp_on),
    .cpu_on     (cpu_on),
    .grp_src    (grp_src),
    .grp_sel_q  (grp_sel_q),
    .fs_q       (fs_q),
    .fdc_q      (fdc_q)
);

// File: tb/sim_clk_out_gater.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected state of each output.
// The monitor counts rising edges over a window and compares the result.
// Codes: 0 = stopped at rest level, 1 = running (33 MHz for group outputs),
// 2 = running at 66 MHz (group outputs only), 3 = wrong rate or rest level.
module sim_clk_out_gater;

    localparam int CLK_PERIOD = 30;
    localparam int NPCI = 8, NGRP = 4, NREF = 3, NCPU = 2;
    localparam int NOUT = NPCI + 1 + NGRP + NREF + NCPU;
    localparam int SETTLE = 400;
    localparam int WINDOW = 600;
    localparam int GBASE = NPCI + 1;
    localparam int CBASE = NPCI + 1 + NGRP + NREF;

    logic clk_33 = 0, clk_66 = 0, clk_ref = 0;
    logic [NCPU-1:0] clk_cpu = '0;
    logic rst_n = 0, pci_stop_n = 1, pcif_en = 1, strap_fdc24 = 1;
    logic [NPCI-1:0] pci_en = '1, pci_freerun = '0;
    logic [NGRP-1:0] grp_en = '1;
    logic [NREF-1:0] ref_en = '1;
    logic [NCPU-1:0] cpu_run = '1;
    logic [1:0] strap_grp_sel = 2'b10;
    logic [3:0] strap_fsel = 4'b0111;

    logic [NPCI-1:0] pci_clk;
    logic pcif_clk, fdc_is_24;
    logic [NGRP-1:0] grp_clk;
    logic [NREF-1:0] ref_clk;
    logic [NCPU-1:0] cpu_clk_t, cpu_clk_c;
    logic [NOUT-1:0] out_oe;

    always #(CLK_PERIOD/2) clk_33 = ~clk_33;
    always #(CLK_PERIOD/4.0) clk_66 = ~clk_66;
    always #35 clk_ref = ~clk_ref;
    always #5 clk_cpu = ~clk_cpu;

    clk_out_gater u0 (.*);

    wire [NOUT-1:0] all_out = {cpu_clk_t, ref_clk, grp_clk, pcif_clk, pci_clk};

    int edge_cnt [NOUT];
    logic [NOUT-1:0] prev_out = '0;
    int vectors = 0, miscompares = 0;

    // Free-running rising-edge counters for every output.
    always @(all_out) begin
        for (int b = 0; b < NOUT; b++)
            if (all_out[b] === 1'b1 && prev_out[b] === 1'b0) edge_cnt[b]++;
        prev_out = all_out;
    end

    typedef struct { int idx; int exp; string req; } item_t;
    item_t sb_q[$];

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: queue the expected state of every output.
    task automatic push_expect(logic [NPCI-1:0] pci, logic pcif, logic [NGRP-1:0] grun,
                               logic [NGRP-1:0] gslow, logic [NREF-1:0] rf,
                               logic [NCPU-1:0] cpu, string req);
        for (int i = 0; i < NPCI; i++) sb_q.push_back('{i, int'(pci[i]), req});
        sb_q.push_back('{NPCI, int'(pcif), req});
        for (int j = 0; j < NGRP; j++)
            sb_q.push_back('{GBASE + j, grun[j] ? (gslow[j] ? 1 : 2) : 0, req});
        for (int k = 0; k < NREF; k++) sb_q.push_back('{GBASE + NGRP + k, int'(rf[k]), req});
        for (int c = 0; c < NCPU; c++) sb_q.push_back('{CBASE + c, int'(cpu[c]), req});
    endtask

    // Monitor: measure a window, then pop and compare every queued item.
    task automatic measure();
        int c0 [NOUT];
        for (int b = 0; b < NOUT; b++) c0[b] = edge_cnt[b];
        #(WINDOW);
        while (sb_q.size() > 0) begin
            item_t it = sb_q.pop_front();
            int d = edge_cnt[it.idx] - c0[it.idx];
            int act;
            if (d == 0) begin
                act = (all_out[it.idx] === 1'b0) ? 0 : 3;
                if (it.idx >= CBASE && cpu_clk_c[it.idx - CBASE] !== 1'b1) act = 3;
            end else if (it.idx >= GBASE && it.idx < GBASE + NGRP) begin
                act = (d >= 30) ? 2 : ((d >= 10 && d <= 25) ? 1 : 3);
            end else begin
                act = 1;
            end
            chk(it.req, $sformatf("output %0d state", it.idx), act, it.exp);
        end
    endtask

    task automatic do_reset(logic [1:0] sel, logic [3:0] fs, logic fdc);
        rst_n = 0;
        #300;
        strap_grp_sel = sel; strap_fsel = fs; strap_fdc24 = fdc;
        #300;
        rst_n = 1;
        #(SETTLE);
    endtask

    initial begin
        #3;
        #200;
        // R10: everything rests while in reset.
        push_expect('0, 0, '0, '0, '0, '0, "R10");
        measure();
        rst_n = 1;
        #(SETTLE);
        // R3: split 10 puts outputs 2-3 on 33 MHz; R5/R11 all enabled run.
        push_expect('1, 1, 4'b1111, 4'b1100, '1, '1, "R3");
        measure();
        chk("R8", "out_oe nonzero code", int'(out_oe), (1 << NOUT) - 1);
        chk("R9", "fdc_is_24 frozen 1", int'(fdc_is_24), 1);

        // R1/R2/R4: stop with all freerun bits set; only masked outputs 3..5 survive.
        pci_stop_n = 0; pci_freerun = '1;
        #(SETTLE);
        push_expect(8'b0011_1000, 1, 4'b0011, 4'b1100, '1, '1, "R2");
        measure();

        // R1: stop with freerun clear halts the whole bank but not the free output.
        pci_freerun = '0;
        #(SETTLE);
        push_expect('0, 1, 4'b0011, 4'b1100, '1, '1, "R1");
        measure();

        // R5/R6/R11: individual run bits.
        pci_stop_n = 1; pci_en = 8'b1010_0101; pcif_en = 0;
        grp_en = 4'b0110; ref_en = 3'b010; cpu_run = 2'b01;
        #(SETTLE);
        push_expect(8'b1010_0101, 0, 4'b0110, 4'b1100, 3'b010, 2'b01, "R5");
        measure();
        chk("R6", "cpu_clk_c[1] parked", int'(cpu_clk_c[1]), 1);

        // R9: strap changes after release do nothing.
        pci_en = '1; pcif_en = 1; grp_en = '1; ref_en = '1; cpu_run = '1;
        strap_grp_sel = 2'b00; strap_fsel = 4'b0000; strap_fdc24 = 0;
        #(SETTLE);
        push_expect('1, 1, 4'b1111, 4'b1100, '1, '1, "R9");
        measure();
        chk("R9", "out_oe after late strap", int'(out_oe), (1 << NOUT) - 1);
        chk("R9", "fdc_is_24 after late strap", int'(fdc_is_24), 0 + 1);

        // R3/R8: split 11 and code 0000.
        do_reset(2'b11, 4'b0000, 1'b0);
        push_expect('1, 1, 4'b1111, 4'b1110, '1, '1, "R3");
        measure();
        chk("R8", "out_oe code 0000", int'(out_oe), 0);
        chk("R9", "fdc_is_24 frozen 0", int'(fdc_is_24), 0);

        // R4: split 00, all group outputs at 66 MHz keep running through a stop.
        do_reset(2'b00, 4'b0001, 1'b1);
        pci_stop_n = 0;
        #(SETTLE);
        push_expect('0, 1, 4'b1111, 4'b0000, '1, '1, "R4");
        measure();
        chk("R8", "out_oe code 0001", int'(out_oe), (1 << NOUT) - 1);

        // R3: split 01 puts only output 3 on 33 MHz.
        pci_stop_n = 1;
        do_reset(2'b01, 4'b0111, 1'b1);
        push_expect('1, 1, 4'b1111, 4'b1000, '1, '1, "R3");
        measure();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule